// File: doc/BRIEF.md
# Decade Divider on a Twisted Ring

This block divides its clock by ten. The count is kept in a five-flop twisted ring: the first flop loads the inverse of the last flop, and every other flop loads its lower neighbour. From the all-zeros state, this shift visits ten states and then returns to all zeros. The ring feeds ten decoded lines, and exactly one of them is high at a time. Each decoded line depends on only two adjacent ring bits.

A carry line is high for the first half of the ten-state cycle. This gives a square wave at one tenth of the clock rate, and its rising edge marks the return to count 0, so several stages can be chained. An active-high inhibit input freezes the count. A synchronous active-high reset returns the ring to all zeros. If the ring is ever disturbed into one of the 22 patterns outside the cycle, the next enabled clock puts it back on the cycle at count 0.

Top module: `decade_johnson_div`

## Requirements
- R1: A rising clock edge with `rst` high sets `dec_o` to 10'b00_0000_0001 (count 0) and `carry_o` to 1. This holds whatever the value of `inhibit`.
- R2: While the ring holds a legal state, exactly one bit of `dec_o` is high. Bit k stands for count k.
- R3: Each rising edge with `rst` and `inhibit` low moves the high bit of `dec_o` from position k to position (k+1) mod 10. Count 9 therefore wraps to count 0.
- R4: Over any ten consecutive enabled edges, each decoded line is high for exactly one clock period.
- R5: `carry_o` is 1 for counts 0 to 4 and 0 for counts 5 to 9. It rises only on entry to count 0.
- R6: An edge with `inhibit` high and `rst` low leaves `dec_o` and `carry_o` unchanged.
- R7: If the ring holds a pattern outside the ten-state cycle, the next edge with `inhibit` low loads all zeros. The outputs then show count 0 with `carry_o` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to count 0 |
| inhibit | input | 1 | Active-high count hold |
| dec_o | output | 10 | One-hot decoded count, bit k high at count k |
| carry_o | output | 1 | High for counts 0 to 4, low for counts 5 to 9 |

## Verification
The hardest situation to reach is an illegal ring pattern. Reset and counting from the ports can never leave the ten-state cycle. To get there, the stimulus overwrites the ring register between clock edges with patterns that have two or more bit boundaries, such as 01010, 11011 and 00100. It does this at several points in the count. The scoreboard then expects count 0 right after the next enabled edge, and normal counting from there on.

// File: rtl/jc_pkg.sv
package jc_pkg;

    localparam int JC_STAGES = 5;
    localparam int JC_COUNTS = 2 * JC_STAGES;

    typedef enum logic [1:0] {
        RING_RESET,
        RING_HOLD,
        RING_SHIFT,
        RING_REPAIR
    } ring_op_e;

endpackage

// File: rtl/jc_ring.sv
module jc_ring
    import jc_pkg::*;
#(
    parameter int STAGES = JC_STAGES,
    localparam int COUNTS = 2 * STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inhibit,
    output logic [STAGES-1:0] state_o
);

    logic [STAGES-1:0] state_q;
    logic [STAGES-1:0] state_d;
    logic              on_cycle;
    ring_op_e          op;

    // Ring pattern for count k: bit i is set when i < k <= i + STAGES.
    function automatic logic [STAGES-1:0] pattern_of(input int k);
        logic [STAGES-1:0] p;
        for (int i = 0; i < STAGES; i++) begin
            p[i] = (k > i) && (k <= i + STAGES);
        end
        return p;
    endfunction

    always_comb begin
        on_cycle = 1'b0;
        for (int k = 0; k < COUNTS; k++) begin
            if (state_q == pattern_of(k)) begin
                on_cycle = 1'b1;
            end
        end
    end

    always_comb begin
        if (rst) begin
            op = RING_RESET;
        end else if (inhibit) begin
            op = RING_HOLD;
        end else if (!on_cycle) begin
            op = RING_REPAIR;
        end else begin
            op = RING_SHIFT;
        end
    end

    always_comb begin
        unique case (op)
            RING_RESET:  state_d = '0;
            RING_HOLD:   state_d = state_q;
            RING_REPAIR: state_d = '0;
            RING_SHIFT:  state_d = {state_q[STAGES-2:0], ~state_q[STAGES-1]};
            default:     state_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign state_o = state_q;

endmodule

// File: rtl/jc_decode.sv
module jc_decode
    import jc_pkg::*;
#(
    parameter int STAGES = JC_STAGES,
    localparam int COUNTS = 2 * STAGES
) (
    input  logic [STAGES-1:0] ring_i,
    output logic [COUNTS-1:0] dec_o,
    output logic              carry_o
);

    for (genvar k = 0; k < COUNTS; k++) begin : g_line
        if (k == 0) begin : g_zero
            assign dec_o[k] = ~ring_i[0] & ~ring_i[STAGES-1];
        end else if (k < STAGES) begin : g_fill
            assign dec_o[k] = ring_i[k-1] & ~ring_i[k];
        end else if (k == STAGES) begin : g_full
            assign dec_o[k] = ring_i[0] & ring_i[STAGES-1];
        end else begin : g_drain
            assign dec_o[k] = ~ring_i[k-STAGES-1] & ring_i[k-STAGES];
        end
    end

    assign carry_o = ~ring_i[STAGES-1];

endmodule

// File: rtl/decade_johnson_div.sv
module decade_johnson_div
    import jc_pkg::*;
#(
    parameter int STAGES = JC_STAGES,
    localparam int COUNTS = 2 * STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inhibit,
    output logic [COUNTS-1:0] dec_o,
    output logic              carry_o
);

    logic [STAGES-1:0] ring_q;

    jc_ring #(.STAGES(STAGES)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .inhibit (inhibit),
        .state_o (ring_q)
    );

    jc_decode #(.STAGES(STAGES)) u_decode (
        .ring_i  (ring_q),
        .dec_o   (dec_o),
        .carry_o (carry_o)
    );

endmodule

module decade_johnson_div_chk #(
    parameter int STAGES = 5,
    localparam int COUNTS = 2 * STAGES
) (
    input logic              clk,
    input logic              rst,
    input logic              inhibit,
    input logic [STAGES-1:0] ring,
    input logic [COUNTS-1:0] dec,
    input logic              carry
);

    // A legal ring has at most one boundary between adjacent bits.
    function automatic logic one_boundary(input logic [STAGES-1:0] r);
        int n;
        n = 0;
        for (int i = 0; i < STAGES - 1; i++) begin
            if (r[i] != r[i+1]) n++;
        end
        return n <= 1;
    endfunction

    logic legal;
    assign legal = one_boundary(ring);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (dec == COUNTS'(1)) && carry);

    p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        legal |-> ($countones(dec) == 1));

    p_advance_r3: assert property (@(posedge clk) disable iff (rst)
        (legal && !inhibit) |=>
            (!legal || (dec == {$past(dec[COUNTS-2:0]), $past(dec[COUNTS-1])})));

    p_carry_half_r5: assert property (@(posedge clk) disable iff (rst)
        legal |-> (carry == (|dec[STAGES-1:0])));

    p_carry_rise_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(carry) && legal) |-> dec[0]);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        inhibit |=> ($stable(dec) && $stable(carry)));

    p_repair_r7: assert property (@(posedge clk) disable iff (rst)
        (!legal && !inhibit) |=> (ring == '0));

endmodule

bind decade_johnson_div decade_johnson_div_chk #(.STAGES(STAGES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .inhibit (inhibit),
    .ring    (ring_q),
    .dec     (dec_o),
    .carry   (carry_o)
);

// File: tb/decade_johnson_div_tb.sv
`timescale 1ns/1ps
module decade_johnson_div_tb;

    localparam int NCNT = 10;

    typedef struct {
        logic [NCNT-1:0] dec;
        logic            carry;
        string           tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            inhibit = 1'b0;
    logic [NCNT-1:0] dec_o;
    logic            carry_o;

    int   n_cmp = 0;
    int   n_bad = 0;
    int   cnt = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    decade_johnson_div u_dut (
        .clk     (clk),
        .rst     (rst),
        .inhibit (inhibit),
        .dec_o   (dec_o),
        .carry_o (carry_o)
    );

    function automatic exp_t expect_for(input int c, input string tag);
        exp_t e;
        e.dec   = NCNT'(1) << c;
        e.carry = (c < 5);
        e.tag   = tag;
        return e;
    endfunction

    // Driver: set inputs away from the edge, update the model, queue the expectation.
    task automatic step(input logic r, input logic inh, input string tag);
        @(negedge clk);
        rst     = r;
        inhibit = inh;
        if (r) cnt = 0;
        else if (!inh) cnt = (cnt + 1) % NCNT;
        sb.push_back(expect_for(cnt, tag));
    endtask

    task automatic step_corrupt(input logic [4:0] pat);
        @(negedge clk);
        rst     = 1'b0;
        inhibit = 1'b0;
        force u_dut.u_ring.state_q = pat;
        #0.5;
        release u_dut.u_ring.state_q;
        cnt = 0;
        sb.push_back(expect_for(cnt, "R7 repair to count 0"));
    endtask

    // Monitor: compare one result after each edge.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_cmp++;
            if (dec_o !== e.dec || carry_o !== e.carry) begin
                n_bad++;
                $display("FAIL %s: dec=%b carry=%b, expected dec=%b carry=%b",
                         e.tag, dec_o, carry_o, e.dec, e.carry);
            end
        end
    end

    // R4: per-line high count over one full cycle
    task automatic check_duty;
        int hits[NCNT];
        for (int k = 0; k < NCNT; k++) hits[k] = 0;
        for (int s = 0; s < NCNT; s++) begin
            step(1'b0, 1'b0, "R3 R4 duty sweep");
            @(posedge clk);
            #1.5;
            for (int k = 0; k < NCNT; k++) if (dec_o[k]) hits[k]++;
        end
        for (int k = 0; k < NCNT; k++) begin
            n_cmp++;
            if (hits[k] != 1) begin
                n_bad++;
                $display("FAIL R4: line %0d high for %0d periods, expected 1", k, hits[k]);
            end
        end
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state, also with inhibit high
        step(1'b1, 1'b0, "R1 reset state");
        step(1'b1, 1'b1, "R1 reset with inhibit");
        step(1'b1, 1'b0, "R1 reset state");
        // R2 R3 R5: two and a half cycles of counting, wrap included
        for (int i = 0; i < 25; i++) step(1'b0, 1'b0, "R2 R3 R5 count");
        check_duty();
        // R6: interleaved inhibit
        for (int i = 0; i < 12; i++) step(1'b0, (i % 3) != 2, "R6 inhibit hold");
        step(1'b0, 1'b1, "R6 inhibit hold");
        step(1'b0, 1'b1, "R6 inhibit hold");
        // R1: reset mid count while inhibited
        step(1'b1, 1'b1, "R1 reset overrides inhibit");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R3 count after reset");
        // R7: illegal patterns at various points
        step_corrupt(5'b01010);
        for (int i = 0; i < 7; i++) step(1'b0, 1'b0, "R7 count after repair");
        step_corrupt(5'b11011);
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, "R7 R5 count after repair");
        step_corrupt(5'b00100);
        for (int i = 0; i < 11; i++) step(1'b0, 1'b0, "R7 R3 count after repair");
        step(1'b0, 1'b0, "R3 drain");
        @(negedge clk);
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule